// File: doc/BRIEF.md
# Asynchronous Trigger Capture with Busy Gating

This block takes an external trigger with no fixed phase relation to the system clock, which runs at 40 MHz in the target system. The trigger's rising edge drives an analogue hold strobe through a path that contains no clock-domain flops. Timing resolution is therefore set by the trigger itself and not by the clock period. The trigger is also brought into the clock domain through a synchroniser. Its synchronised falling edge produces a single-cycle request that tells the front-end to start sending the event to the back-end. Because the request is launched from the falling edge, every unit that sees the same trigger issues it in the same clock cycle, even when the rising edge lands close to a clock edge.

Once a trigger is accepted, a busy flag is raised, and triggers that arrive while it is high are refused and counted. The readout logic drops the flag with a release pulse. A trigger that is detected in the same cycle as a release is settled by a build-time policy, so the flag can never stay high with no event recorded. A run-start pulse clears the flag, any transfer still waiting, and both counters.

Top module: `trig_capture`

## Requirements
- R1: During reset and right after it, `busy_o`, `hold_o` and `xfer_start_o` are 0, and both counters read 0.
- R2: A rising trigger edge that arrives while `busy_o` is 0 drives `hold_o` to 1 before any further clock edge. A rising edge that arrives while `busy_o` is 1 leaves `hold_o` at 0.
- R3: Once raised, `hold_o` stays 1 for at least HOLD_CYCLES clock cycles and returns to 0 within HOLD_CYCLES+SYNC_STAGES+4 cycles. This holds whatever the trigger does during that time.
- R4: An accepted trigger sets `busy_o` to 1 and adds one to `acc_count_o`.
- R5: Each accepted trigger gives exactly one `xfer_start_o` pulse. The pulse is one cycle wide and appears 2 to 5 clock cycles after the trigger's falling edge.
- R6: A trigger that arrives while `busy_o` is 1, and that does not meet a release, adds one to `rej_count_o`. It leaves `acc_count_o` and `busy_o` unchanged and produces no `xfer_start_o` pulse.
- R7: A `busy_release` pulse with no colliding trigger clears `busy_o` at the next clock edge.
- R8: A trigger detected in the same cycle as `busy_release`, while busy, is handled by POLICY. With COLL_ACCEPT (value 0), the trigger is counted as accepted, `busy_o` stays 1 and one transfer follows. With COLL_DROP (value 1), the trigger is counted as rejected, `busy_o` goes to 0 and no transfer follows.
- R9: A `run_start` pulse clears `busy_o`, `acc_count_o` and `rej_count_o` at the next clock edge.
- R10: After `busy_o` has been released, the next trigger raises `hold_o` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| trig_in | input | 1 | External trigger, any phase, high for at least 3 cycles |
| busy_release | input | 1 | Synchronous one-cycle pulse that releases busy |
| run_start | input | 1 | Synchronous one-cycle pulse that clears state at run start |
| hold_o | output | 1 | Asynchronously set hold strobe of fixed minimum width |
| xfer_start_o | output | 1 | One-cycle request to start the event transfer |
| busy_o | output | 1 | Trigger gate, high while an event is outstanding |
| acc_count_o | output | CNT_W | Accepted trigger count, wraps |
| rej_count_o | output | CNT_W | Rejected trigger count, wraps |

## Verification
If the busy or pending state is wrong, a trigger is refused that should have been accepted, or the reverse. That shows at the ports as a missing or extra `xfer_start_o` pulse, a hold that fails to fire, and a counter that is off by one. All of these can be seen within a few cycles of that trigger's falling edge. A fault in the hold clearing shows up as a hold strobe that is too short or never ends, which can be observed within about a dozen cycles. A wrong collision policy changes the busy level one cycle after the release.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   // How a trigger that meets a busy release in the same cycle is resolved
   typedef enum logic {
      COLL_ACCEPT = 1'b0,
      COLL_DROP   = 1'b1
   } coll_policy_e;

   // Edge events of the synchronised trigger
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_evt_t;
endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge
   import tcap_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      async_i,
   output edge_evt_t evt_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("tcap_sync_edge: STAGES must be at least 2");
   end

   // Shift chain; index 0 is the metastability-exposed flop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[LAST];
      end
   end

   always_comb begin
      evt_o.rise = chain_q[LAST] & ~last_q;
      evt_o.fall = ~chain_q[LAST] & last_q;
   end
endmodule

// File: rtl/tcap_hold_gen.sv
module tcap_hold_gen #(
   parameter int HOLD_CYCLES = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic arm_i,
   output logic hold_o
);
   localparam int CW   = $clog2(HOLD_CYCLES + 1);
   localparam int LAST = SYNC_STAGES - 1;

   logic                   hold_q;
   logic                   clr_q;
   logic                   hold_rst;
   logic [SYNC_STAGES-1:0] hsync_q;
   logic [CW-1:0]          cnt_q;

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("tcap_hold_gen: HOLD_CYCLES must be at least 1");
   end

   assign hold_rst = clr_q | ~rst_n;

   // The trigger edge itself clocks the hold flop: no clock in the set path
   always_ff @(posedge trig_i or posedge hold_rst) begin
      if (hold_rst) hold_q <= 1'b0;
      else          hold_q <= hold_q | arm_i;
   end

   // Width control in the clock domain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_q <= '0;
         cnt_q   <= '0;
         clr_q   <= 1'b0;
      end else begin
         hsync_q <= {hsync_q[SYNC_STAGES-2:0], hold_q};
         if (!hsync_q[LAST]) begin
            cnt_q <= '0;
            clr_q <= 1'b0;
         end else if (cnt_q == CW'(HOLD_CYCLES - 1)) begin
            clr_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign hold_o = hold_q;

   AST_CLR_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr_q) |-> $past(hsync_q[LAST])); // R3
endmodule

// File: rtl/tcap_busy_ctrl.sv
module tcap_busy_ctrl
   import tcap_pkg::*;
#(
   parameter int           CNT_W  = 16,
   parameter coll_policy_e POLICY = COLL_ACCEPT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  edge_evt_t        evt_i,
   input  logic             release_i,
   input  logic             run_i,
   output logic             busy_o,
   output logic             xfer_o,
   output logic [CNT_W-1:0] acc_o,
   output logic [CNT_W-1:0] rej_o
);
   logic             busy_q, pend_q, xfer_q;
   logic [CNT_W-1:0] acc_q, rej_q;
   logic             accept, reject, collide;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("tcap_busy_ctrl: CNT_W must be at least 1");
   end

   assign collide = evt_i.rise & busy_q & release_i;

   if (POLICY == COLL_ACCEPT) begin : g_coll_accept
      assign accept = evt_i.rise & (~busy_q | release_i);
      assign reject = evt_i.rise & busy_q & ~release_i;
      AST_COLL_KEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         (collide && !run_i) |=> busy_q); // R8
   end else begin : g_coll_drop
      assign accept = evt_i.rise & ~busy_q;
      assign reject = evt_i.rise & busy_q;
      AST_COLL_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         (collide && !run_i) |=> !busy_q); // R8
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= 1'b0;
         xfer_q <= 1'b0;
         acc_q  <= '0;
         rej_q  <= '0;
      end else if (run_i) begin
         busy_q <= 1'b0;
         pend_q <= 1'b0;
         xfer_q <= 1'b0;
         acc_q  <= '0;
         rej_q  <= '0;
      end else begin
         if (accept)         busy_q <= 1'b1;
         else if (release_i) busy_q <= 1'b0;

         if (accept)                 pend_q <= 1'b1;
         else if (evt_i.fall)        pend_q <= 1'b0;

         xfer_q <= evt_i.fall & pend_q;
         acc_q  <= acc_q + CNT_W'(accept);
         rej_q  <= rej_q + CNT_W'(reject);
      end
   end

   assign busy_o = busy_q;
   assign xfer_o = xfer_q;
   assign acc_o  = acc_q;
   assign rej_o  = rej_q;

   AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_q |=> !xfer_q); // R5
   AST_XFER_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.fall && !pend_q) |=> !xfer_q); // R5
   AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !run_i) |=> busy_q); // R4
   AST_REJECT_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && !run_i) |=> (acc_q == $past(acc_q))); // R6
   AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !evt_i.rise && !run_i) |=> !busy_q); // R7
   AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |=> (!busy_q && acc_q == '0 && rej_q == '0)); // R9
endmodule

// File: rtl/trig_capture.sv
module trig_capture
   import tcap_pkg::*;
#(
   parameter int           SYNC_STAGES = 2,
   parameter int           HOLD_CYCLES = 8,
   parameter int           CNT_W       = 16,
   parameter coll_policy_e POLICY      = COLL_ACCEPT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic             busy_release,
   input  logic             run_start,
   output logic             hold_o,
   output logic             xfer_start_o,
   output logic             busy_o,
   output logic [CNT_W-1:0] acc_count_o,
   output logic [CNT_W-1:0] rej_count_o
);
   edge_evt_t evt;
   logic      busy;

   tcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (trig_in),
      .evt_o   (evt)
   );

   tcap_busy_ctrl #(.CNT_W(CNT_W), .POLICY(POLICY)) u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt),
      .release_i (busy_release),
      .run_i     (run_start),
      .busy_o    (busy),
      .xfer_o    (xfer_start_o),
      .acc_o     (acc_count_o),
      .rej_o     (rej_count_o)
   );

   tcap_hold_gen #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_in),
      .arm_i  (~busy),
      .hold_o (hold_o)
   );

   assign busy_o = busy;
endmodule

// File: tb/trig_capture_bench.sv
`timescale 1ns/100ps
module trig_capture_bench;
   import tcap_pkg::*;
   localparam int HOLD = 8;
   localparam int SYNC = 2;
   localparam int CW   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0, rel = 1'b0, run = 1'b0;
   logic hold_a, xfer_a, busy_a, hold_d, xfer_d, busy_d;
   logic [CW-1:0] acc_a, rej_a, acc_d, rej_d;

   int n_chk = 0, n_fail = 0;
   int xs_a = 0, xs_d = 0, wide_err = 0;
   logic xp_a = 1'b0, xp_d = 1'b0;
   bit done = 0;
   bit e_busy = 0;
   int e_acc = 0, e_rej = 0;

   always #2 clk = ~clk;

   trig_capture #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .CNT_W(CW), .POLICY(COLL_ACCEPT)) u_trig_capture (
      .clk(clk), .rst_n(rst_n), .trig_in(trig), .busy_release(rel), .run_start(run),
      .hold_o(hold_a), .xfer_start_o(xfer_a), .busy_o(busy_a),
      .acc_count_o(acc_a), .rej_count_o(rej_a));

   trig_capture #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .CNT_W(CW), .POLICY(COLL_DROP)) u_trig_capture_drop (
      .clk(clk), .rst_n(rst_n), .trig_in(trig), .busy_release(rel), .run_start(run),
      .hold_o(hold_d), .xfer_start_o(xfer_d), .busy_o(busy_d),
      .acc_count_o(acc_d), .rej_count_o(rej_d));

   always @(negedge clk) begin
      if (xfer_a) xs_a++;
      if (xfer_d) xs_d++;
      if (xfer_a && xp_a) wide_err++;
      if (xfer_d && xp_d) wide_err++;
      xp_a = xfer_a;
      xp_d = xfer_d;
   end

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_accept(bit busy);
      return !busy;
   endfunction

   task automatic pulse_rel();
      @(negedge clk); rel = 1'b1;
      @(negedge clk); rel = 1'b0;
   endtask

   task automatic pulse_run();
      @(negedge clk); run = 1'b1;
      @(negedge clk); run = 1'b0;
   endtask

   task automatic check_state(string req);
      chk(busy_a == e_busy, {req, " busy"}, busy_a, e_busy);
      chk(int'(acc_a) == e_acc, {req, " acc"}, acc_a, e_acc);
      chk(int'(rej_a) == e_rej, {req, " rej"}, rej_a, e_rej);
      chk(busy_d == e_busy, {req, " busy drop"}, busy_d, e_busy);
      chk(int'(acc_d) == e_acc, {req, " acc drop"}, acc_d, e_acc);
      chk(int'(rej_d) == e_rej, {req, " rej drop"}, rej_d, e_rej);
   endtask

   // One trigger at a random phase; both instances see the same history
   task automatic do_trig(int ph_r, int w, int ph_f);
      bit acc;
      int xa0, xd0, lat;
      acc = exp_accept(e_busy);
      xa0 = xs_a; xd0 = xs_d;
      @(posedge clk); #(ph_r * 0.1); trig = 1'b1;
      #0.5;
      chk(hold_a == acc, "R2/R10 hold at leading edge", hold_a, acc);
      chk(hold_d == acc, "R2/R10 hold at leading edge drop", hold_d, acc);
      repeat (w) @(posedge clk);
      #(ph_f * 0.1); trig = 1'b0;
      lat = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         lat++;
         if (xs_a != xa0) break;
      end
      if (acc) chk(lat >= 2 && lat <= 5, "R5 transfer latency", lat, 3);
      repeat (16) @(negedge clk);
      if (acc) begin e_acc++; e_busy = 1; end
      else e_rej++;
      chk(xs_a - xa0 == int'(acc), "R5/R6 transfer count", xs_a - xa0, acc);
      chk(xs_d - xd0 == int'(acc), "R5/R6 transfer count drop", xs_d - xd0, acc);
      check_state(acc ? "R4" : "R6");
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int xa0, xd0;
      void'($urandom(32'h5EED_7A11));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(hold_a == 0 && xfer_a == 0, "R1 outputs in reset", hold_a, 0);
      check_state("R1");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_state("R1 after reset");

      // R3: hold width with a long trigger
      @(posedge clk); #1; trig = 1'b1;
      #0.5; chk(hold_a == 1, "R3 hold raised", hold_a, 1);
      repeat (HOLD) @(posedge clk);
      #1; chk(hold_a == 1, "R3 hold minimum width", hold_a, 1);
      repeat (SYNC + 4) @(posedge clk);
      #1; chk(hold_a == 0, "R3 hold cleared", hold_a, 0);
      chk(trig == 1, "R3 trigger still high", trig, 1);
      @(posedge clk); #1.3; trig = 1'b0;
      repeat (10) @(negedge clk);
      e_acc = 1; e_busy = 1;
      chk(xs_a == 1, "R5 one transfer", xs_a, 1);
      check_state("R4");

      // R6: trigger while busy
      do_trig(17, 4, 5);

      // R7: release timing
      @(negedge clk); rel = 1'b1;
      @(negedge clk); rel = 1'b0;
      e_busy = 0;
      chk(busy_a == 0, "R7 release clears busy", busy_a, 0);
      check_state("R7");

      // R10: re-armed after release
      do_trig(33, 3, 12);

      // R8: collision of a detected rise with release
      xa0 = xs_a; xd0 = xs_d;
      @(negedge clk); trig = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); rel = 1'b1;
      @(negedge clk); rel = 1'b0;
      chk(busy_a == 1, "R8 accept policy busy", busy_a, 1);
      chk(busy_d == 0, "R8 drop policy busy", busy_d, 0);
      repeat (3) @(posedge clk); #2.7; trig = 1'b0;
      repeat (12) @(negedge clk);
      chk(int'(acc_a) == e_acc + 1, "R8 accept policy acc", acc_a, e_acc + 1);
      chk(int'(rej_a) == e_rej, "R8 accept policy rej", rej_a, e_rej);
      chk(xs_a - xa0 == 1, "R8 accept policy transfer", xs_a - xa0, 1);
      chk(int'(acc_d) == e_acc, "R8 drop policy acc", acc_d, e_acc);
      chk(int'(rej_d) == e_rej + 1, "R8 drop policy rej", rej_d, e_rej + 1);
      chk(xs_d - xd0 == 0, "R8 drop policy transfer", xs_d - xd0, 0);

      // R9: run start clears both instances
      pulse_run();
      e_busy = 0; e_acc = 0; e_rej = 0;
      check_state("R9");

      // Random mix
      for (int it = 0; it < 60; it++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 6) do_trig($urandom_range(1, 38), $urandom_range(3, 6), $urandom_range(1, 38));
         else if (r < 9) begin
            pulse_rel();
            e_busy = 0;
            check_state("R7");
         end else begin
            pulse_run();
            e_busy = 0; e_acc = 0; e_rej = 0;
            check_state("R9");
         end
      end
      chk(wide_err == 0, "R5 pulse width", wide_err, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule